// File: doc/BRIEF.md
# Audio Pre-emphasis, Framing and Windowing Front End

This block sits at the head of a speech feature pipeline. It takes signed 16-bit audio samples, each marked by a one-cycle valid strobe at a low sample rate (16 kHz against a fast system clock). Every accepted sample first goes through a first-order high-frequency boost: the previous input, scaled by a fixed-point coefficient, is subtracted from the current input, and the result is clamped to 16 bits.

The boosted samples are written into a circular store. Each time enough new samples have arrived to complete a frame, the whole frame is replayed at clock rate. Each replayed sample is weighted by a raised-cosine (Hamming) coefficient taken from an internal table that is computed at elaboration. Consecutive frames share samples, because the frame advance is shorter than the frame. The store keeps the shared part, so the next frame re-reads it and no input is needed twice. The output is a burst of windowed samples with markers on the first and the last sample of each frame. A later spectral stage uses the markers to delimit its input.

Top module: `audio_frame_front`

## Requirements
- R1: For each accepted sample x with previous accepted sample p, the boosted value is x - ((ALPHA*p + 16384) >>> 15). ALPHA is an unsigned Q1.15 code; the default 31785 stands for 0.97.
- R2: After reset the previous-sample value is zero, so the first boosted value after reset equals the first input.
- R3: The boosted value saturates to the range -32768..32767 and never wraps.
- R4: Boosted samples are numbered from 0 after reset. Frame k holds samples k*FRAME_STEP through k*FRAME_STEP+FRAME_LEN-1. The first frame follows sample FRAME_LEN-1, and each further frame follows every FRAME_STEP-th sample after that.
- R5: Output sample n of a frame is (s*w(n) + 16384) >>> 15. Here s is the boosted sample and w(n) = round(32768*(0.54 - 0.46*cos(2*pi*n/(FRAME_LEN-1)))), an unsigned Q1.15 code.
- R6: A frame leaves as FRAME_LEN consecutive cycles with out_valid high and no gap.
- R7: out_first is high only with out_valid on sample 0 of a frame, and out_last only on sample FRAME_LEN-1. The two never coincide.
- R8: While reset is asserted and directly after it, out_valid, out_first and out_last are low.
- R9: Samples that arrive while a frame is being replayed are stored without disturbing that frame, provided fewer than FRAME_STEP of them arrive within one replay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Windowed output sample is valid |
| out_data | output | 16 | Signed windowed sample |
| out_first | output | 1 | Marks sample 0 of a frame |
| out_last | output | 1 | Marks the final sample of a frame |

## Verification
A rising counter input gives small, steadily growing boosted values. With these, a wrong coefficient, a misaligned frame start or a shifted window index shows up as an offset pattern across the frame. Alternating full-scale extremes drive the filter into both saturation limits and separate clamping from wrapping. Full-range random samples, sent with random gaps between strobes, check the rounding of both multiplies. The gaps also let new samples arrive during a replay. A reset in the middle of a stream shows that the previous-sample value and the frame numbering both restart.

// File: rtl/afe_pkg.sv
package afe_pkg;
  localparam int  SAMPLE_W = 16;
  localparam int  COEF_W   = 16;
  localparam real PI_R     = 3.14159265358979;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [COEF_W-1:0]          coef_t;

  // Raised-cosine weight as unsigned Q1.15 (1.0 -> 32768)
  function automatic coef_t hamming_q15(input int n, input int len);
    real w;
    w = 0.54 - 0.46 * $cos(2.0 * PI_R * real'(n) / real'(len - 1));
    return coef_t'($rtoi(w * 32768.0 + 0.5));
  endfunction

  // Clamp a wide signed value into the sample range
  function automatic sample_t clamp16(input logic signed [39:0] v);
    if (v > 40'sd32767)       return sample_t'(16'sh7fff);
    else if (v < -40'sd32768) return sample_t'(16'sh8000);
    else                      return sample_t'(v[15:0]);
  endfunction
endpackage

// File: rtl/afe_preemph.sv
module afe_preemph
  import afe_pkg::*;
#(
  parameter int ALPHA = 31785
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  sample_t in_data,
  output logic    pe_valid,
  output sample_t pe_data
);
  localparam logic [COEF_W-1:0] ALPHA_C = COEF_W'(ALPHA);

  sample_t              prev_q, prev_d;
  sample_t              data_q, data_d;
  logic                 valid_q, valid_d;
  logic signed [32:0]   prod;
  logic signed [32:0]   scaled;
  logic signed [39:0]   diff;

  always_comb begin
    prod    = $signed({1'b0, ALPHA_C}) * prev_q;
    scaled  = (prod + 33'sd16384) >>> 15;
    diff    = 40'(in_data) - 40'(scaled);
    prev_d  = prev_q;
    data_d  = data_q;
    valid_d = in_valid;
    if (in_valid) begin
      prev_d = in_data;
      data_d = clamp16(diff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign pe_valid = valid_q;
  assign pe_data  = data_q;

  AST_PE_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == 16'sh7fff && prev_q[15]) |=> (pe_data == 16'sh7fff)); // R3
  AST_PE_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == 16'sh8000 && !prev_q[15] && prev_q != '0) |=> (pe_data == 16'sh8000)); // R3
  AST_PE_ZERO_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prev_q == '0) |=> (pe_data == $past(in_data))); // R2
endmodule

// File: rtl/afe_framebuf.sv
module afe_framebuf
  import afe_pkg::*;
#(
  parameter int FRAME_LEN  = 400,
  parameter int FRAME_STEP = 160
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pe_valid,
  input  sample_t                      pe_data,
  output logic                         rd_valid,
  output sample_t                      rd_data,
  output logic [$clog2(FRAME_LEN)-1:0] rd_idx
);
  localparam int DEPTH = FRAME_LEN + FRAME_STEP;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam int BACK  = FRAME_STEP + 1;   // (wr - (LEN-1)) mod DEPTH

  sample_t            mem [DEPTH];
  logic [PTR_W-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [IDX_W-1:0]   togo_q, togo_d, idx_q, idx_d;
  logic               busy_q, busy_d;
  logic               start;
  logic [PTR_W:0]     first_sum;
  logic [PTR_W-1:0]   first_slot;

  always_comb begin
    first_sum = {1'b0, wr_q} + (PTR_W+1)'(BACK);
    if (first_sum >= (PTR_W+1)'(DEPTH)) first_sum = first_sum - (PTR_W+1)'(DEPTH);
    first_slot = first_sum[PTR_W-1:0];
  end

  always_comb begin
    wr_d   = wr_q;
    togo_d = togo_q;
    start  = 1'b0;
    if (pe_valid) begin
      wr_d = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (togo_q == '0) begin
        start  = 1'b1;
        togo_d = IDX_W'(FRAME_STEP-1);
      end else begin
        togo_d = togo_q - 1'b1;
      end
    end
    busy_d = busy_q;
    idx_d  = idx_q;
    rd_d   = rd_q;
    if (busy_q) begin
      rd_d  = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_W'(FRAME_LEN-1)) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end
    end
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      rd_d   = first_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      togo_q <= IDX_W'(FRAME_LEN-1);
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      togo_q <= togo_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pe_valid) mem[wr_q] <= pe_data;
  end

  assign rd_valid = busy_q;
  assign rd_data  = mem[rd_q];
  assign rd_idx   = idx_q;

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R9
  AST_REPLAY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(idx_q) == IDX_W'(FRAME_LEN-1))); // R6
endmodule

// File: rtl/afe_window.sv
module afe_window
  import afe_pkg::*;
#(
  parameter int FRAME_LEN = 400
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_valid,
  input  sample_t                      rd_data,
  input  logic [$clog2(FRAME_LEN)-1:0] rd_idx,
  output logic                         out_valid,
  output sample_t                      out_data,
  output logic                         out_first,
  output logic                         out_last
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  coef_t rom [FRAME_LEN];
  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_rom
    localparam coef_t W = hamming_q15(g, FRAME_LEN);
    assign rom[g] = W;
  end

  coef_t              coef;
  logic signed [32:0] prod;
  logic signed [32:0] rnd;
  sample_t            data_q, data_d;
  logic               valid_q, first_q, last_q;
  logic               valid_d, first_d, last_d;

  always_comb begin
    coef    = rom[rd_idx];
    prod    = rd_data * $signed({1'b0, coef});
    rnd     = (prod + 33'sd16384) >>> 15;
    valid_d = rd_valid;
    first_d = rd_valid && (rd_idx == '0);
    last_d  = rd_valid && (rd_idx == IDX_W'(FRAME_LEN-1));
    data_d  = data_q;
    if (rd_valid) data_d = clamp16(40'(rnd));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_first = first_q;
  assign out_last  = last_q;

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> $past(out_valid)); // R6
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid || out_first)); // R6
  AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first || out_last) |-> out_valid); // R7
  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_first, out_last})); // R7
endmodule

// File: rtl/audio_frame_front.sv
module audio_frame_front
  import afe_pkg::*;
#(
  parameter int FRAME_LEN  = 400,
  parameter int FRAME_STEP = 160,
  parameter int ALPHA      = 31785
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        out_first,
  output logic        out_last
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             pe_valid, rd_valid;
  sample_t          pe_data, rd_data, win_data;
  logic [IDX_W-1:0] rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  afe_preemph #(.ALPHA(ALPHA)) u_pe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .in_data  (sample_t'(in_data)),
    .pe_valid (pe_valid),
    .pe_data  (pe_data)
  );

  afe_framebuf #(.FRAME_LEN(FRAME_LEN), .FRAME_STEP(FRAME_STEP)) u_fb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pe_valid (pe_valid),
    .pe_data  (pe_data),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx)
  );

  afe_window #(.FRAME_LEN(FRAME_LEN)) u_win (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .out_valid (out_valid),
    .out_data  (win_data),
    .out_first (out_first),
    .out_last  (out_last)
  );

  assign out_data = win_data;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> !(out_valid || out_first || out_last)); // R8
endmodule

// File: tb/audio_frame_front_test.sv
module audio_frame_front_test;
  localparam int L     = 24;
  localparam int S     = 10;
  localparam int ALPHA = 31785;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid, out_first, out_last;
  logic [15:0] out_data;

  audio_frame_front #(.FRAME_LEN(L), .FRAME_STEP(S), .ALPHA(ALPHA)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last));

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int filt [4096];
  int nsamp  = 0;
  int prev_x = 0;
  int m_idx  = 0;
  int m_frm  = 0;
  bit prev_ov = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int boost(input int x, input int p);
    return sat(x - ((ALPHA * p + 16384) >>> 15));
  endfunction

  function automatic int wcoef(input int n);
    real w;
    w = 0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * real'(n) / real'(L - 1));
    return $rtoi(w * 32768.0 + 0.5);
  endfunction

  function automatic int windowed(input int s, input int n);
    return sat((s * wcoef(n) + 16384) >>> 15);
  endfunction

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_frm = 0; prev_ov = 1'b0;
    end else begin
      if (out_valid) begin
        chk($signed(out_data) == windowed(filt[m_frm*S + m_idx], m_idx),
            "R1/R4/R5 data", $signed(out_data), windowed(filt[m_frm*S + m_idx], m_idx));
        chk(out_first == (m_idx == 0), "R7 first marker", out_first, m_idx == 0);
        chk(out_last == (m_idx == L-1), "R7 last marker", out_last, m_idx == L-1);
        if (m_idx != 0) chk(prev_ov, "R6 gap inside frame", prev_ov, 1);
        m_idx++;
        if (m_idx == L) begin m_idx = 0; m_frm++; end
      end else begin
        chk(!out_first && !out_last, "R7 marker without valid", {out_first, out_last}, 0);
      end
      prev_ov = out_valid;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    nsamp = 0;
    prev_x = 0;   // R2: previous sample cleared
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_first && !out_last, "R8 reset outputs",
        {out_valid, out_first, out_last}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid, "R8 idle after reset", out_valid, 0);
  endtask

  task automatic send(input int x, input int gap);
    filt[nsamp] = boost(x, prev_x);
    prev_x = x;
    nsamp++;
    in_data  = 16'(x);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic finish_segment(input string tag);
    int expf;
    repeat (L + 12) @(negedge clk);
    expf = (nsamp >= L) ? (nsamp - L) / S + 1 : 0;
    chk(m_frm == expf, {"R4 frame count ", tag}, m_frm, expf);
    chk(m_idx == 0, {"R6 frame completed ", tag}, m_idx, 0);
  endtask

  initial begin
    int r;
    r = $urandom(32'd1234);
    do_reset();
    // Rising counter; R2 covered by the first output of the first frame
    for (int i = 0; i < 100; i++) send(i, 4);
    finish_segment("counter");

    // Mid-stream reset, then too few samples for a frame (R4)
    do_reset();
    for (int i = 0; i < L-1; i++) send(1000 + 37*i, 4);
    finish_segment("short");

    // Alternating extremes drive both clamp limits (R3)
    do_reset();
    for (int i = 0; i < 60; i++) send((i % 2) ? -32768 : 32767, 4);
    chk(filt[1] == -32768 && filt[2] == 32767, "R3 model clamp", filt[1], -32768);
    finish_segment("extremes");

    // Random full range with random gaps; inputs land during replays (R9)
    do_reset();
    for (int i = 0; i < 200; i++) begin
      int v, g;
      v = int'($signed(16'($urandom)));
      g = 4 + int'($urandom % 4);
      send(v, g);
    end
    finish_segment("random");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule